// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block predicts whether a conditional branch will be taken and supplies the target address last seen for it. A small table of perceptrons is indexed by the branch address mixed with the global direction history. Each entry holds a signed 8-bit bias, one signed 8-bit weight per history bit, and a cached target. The prediction is the sign of a score. The score is the bias plus the sum of the weights, where each weight is added when its history bit is 1 (taken) and subtracted when the bit is 0 (not taken).

Every accepted prediction pushes its score and the history it saw into an in-flight queue. Resolved branches arrive in program order and consume the oldest queue entry. That entry's stored score and history drive training, so training matches what the predictor saw at prediction time. A flush removes the youngest entry and rewinds the history to that entry's snapshot. The history is advanced speculatively on each prediction and repaired when a resolved branch turns out mispredicted.

The queue is controlled by a three-state occupancy machine:
- **Q_EMPTY**: the queue holds nothing.
- **Q_PART**: the queue holds some entries but is not full.
- **Q_FULL**: every slot is in use.

It has four transitions:
- **fill**: Q_EMPTY to Q_PART, on a push.
- **top**: Q_PART to Q_FULL, on a push that takes the last free slot.
- **drain**: Q_PART to Q_EMPTY, on a pop that removes the last entry.
- **open**: Q_FULL to Q_PART, on any pop.

Each cycle the top level chooses one operation: OP_UPDATE, OP_FLUSH, OP_PREDICT or OP_IDLE.

Top module: `perc_predictor`

## Requirements
- R1: After reset all weights, targets and the history are zero and the queue is empty, so the outputs are pred_taken=1, pred_target=0 and stall=0.
- R2: The score is the bias plus, for each history bit j, weight j+1 if bit j is 1 or minus weight j+1 if bit j is 0. pred_taken is 1 exactly when the score is at least zero.
- R3: The table index is the low IDX_W bits of (address shifted right by 2) XOR the history, zero-extended. History bits above IDX_W do not affect the index.
- R4: An accepted prediction shifts the predicted direction into history bit 0, and the history is kept to HIST_W bits.
- R5: Each accepted prediction queues its score and its history snapshot. An update uses the oldest queued entry, and it indexes the table with the update address and that entry's snapshot.
- R6: An update trains the entry when it was mispredicted or when the magnitude of its stored score is at most THRESH. Training moves the bias by +1 if taken and -1 if not taken. It moves weight j+1 by +1 when snapshot bit j equals the outcome and by -1 otherwise. Every weight saturates at -128 and +127.
- R7: A taken update writes upd_target into the entry's target. A not-taken update leaves the target unchanged.
- R8: A mispredicted update sets the history to (snapshot shifted left by 1) OR the outcome, kept to HIST_W bits.
- R9: A flush removes the youngest queue entry and restores the history to that entry's snapshot. It does not change the table.
- R10: stall is 1 exactly when the queue holds Q_DEPTH entries. A prediction offered while stall is 1 is ignored.
- R11: At most one operation is taken per cycle, with update first, then flush, then predict. The lower-priority inputs are ignored whenever a higher one is valid.
- R12: An update or a flush that arrives when the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request |
| pred_addr | input | ADDR_W | Address of the branch to predict |
| pred_taken | output | 1 | Predicted direction for pred_addr (combinational) |
| pred_target | output | ADDR_W | Cached target for pred_addr (combinational) |
| stall | output | 1 | Queue is full; predictions are refused |
| upd_valid | input | 1 | Resolution of the oldest in-flight branch |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target |
| flush_valid | input | 1 | Drop the youngest in-flight branch |

## Verification
The hardest condition to reach is weight saturation. With a small threshold, training stops long before any weight nears its limit. The bench therefore drives a second instance with a threshold larger than any reachable score, so that it trains on every update. It pumps one branch hundreds of times taken and then hundreds of times not taken, and a reference model in the bench checks every prediction made on the way. Flush-based history rewinds and mispredict repairs are reached by random mixes of predictions, in-order resolutions and flushes. Those mixes include cycles where all three operations are requested at once.

// File: rtl/perc_pkg.sv
package perc_pkg;

    typedef logic signed [7:0] weight_t;

    localparam weight_t W_MAX = 8'sd127;
    localparam weight_t W_MIN = -8'sd128;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PART,
        Q_FULL
    } q_state_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_UPDATE,
        OP_FLUSH,
        OP_PREDICT
    } op_e;

    // One saturating training step toward or away from the outcome.
    function automatic weight_t sat_step(input weight_t w, input logic up);
        weight_t r;
        if (up) r = (w == W_MAX) ? w : weight_t'(w + 8'sd1);
        else    r = (w == W_MIN) ? w : weight_t'(w - 8'sd1);
        return r;
    endfunction

endpackage

// File: rtl/perc_dot.sv
module perc_dot #(
    parameter int HIST_W = 4,
    parameter int DOT_W  = 12
) (
    input  logic [HIST_W:0][7:0]     weights,
    input  logic [HIST_W-1:0]        hist,
    output logic signed [DOT_W-1:0]  score
);

    logic signed [DOT_W-1:0] term [HIST_W+1];

    // Bias input is fixed at +1.
    assign term[0] = DOT_W'($signed(weights[0]));

    for (genvar gi = 1; gi <= HIST_W; gi++) begin : g_term
        logic signed [DOT_W-1:0] ext;
        assign ext      = DOT_W'($signed(weights[gi]));
        assign term[gi] = hist[gi-1] ? ext : -ext;
    end

    always_comb begin
        score = '0;
        for (int i = 0; i <= HIST_W; i++) begin
            score = score + term[i];
        end
    end

endmodule

// File: rtl/perc_train.sv
module perc_train
    import perc_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic [HIST_W:0][7:0] w_in,
    input  logic [HIST_W-1:0]    snap,
    input  logic                 taken,
    output logic [HIST_W:0][7:0] w_out
);

    logic [HIST_W:0] agree;

    for (genvar gi = 0; gi <= HIST_W; gi++) begin : g_wt
        if (gi == 0) begin : g_bias
            assign agree[gi] = taken;
        end else begin : g_hist
            assign agree[gi] = (snap[gi-1] == taken);
        end
        assign w_out[gi] = sat_step(weight_t'(w_in[gi]), agree[gi]);

        always_comb begin
            AST_STEP_ONE: assert ((w_out[gi] == w_in[gi])
                || ($signed(w_out[gi]) - $signed(w_in[gi]) == 1)
                || ($signed(w_in[gi]) - $signed(w_out[gi]) == 1)); // R6
        end
    end

endmodule

// File: rtl/perc_table.sv
module perc_table #(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 4,
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_a_idx,
    output logic [HIST_W:0][7:0]  rd_a_w,
    output logic [ADDR_W-1:0]     rd_a_tgt,
    input  logic [IDX_W-1:0]      rd_b_idx,
    output logic [HIST_W:0][7:0]  rd_b_w,
    input  logic                  wr_w_en,
    input  logic                  wr_t_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [HIST_W:0][7:0]  wr_w,
    input  logic [ADDR_W-1:0]     wr_tgt
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W:0][7:0] wts [ENTRIES];
    logic [ADDR_W-1:0]    tgt [ENTRIES];

    assign rd_a_w   = wts[rd_a_idx];
    assign rd_a_tgt = tgt[rd_a_idx];
    assign rd_b_w   = wts[rd_b_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                wts[i] <= '0;
                tgt[i] <= '0;
            end
        end else begin
            if (wr_w_en) wts[wr_idx] <= wr_w;
            if (wr_t_en) tgt[wr_idx] <= wr_tgt;
        end
    end

endmodule

// File: rtl/perc_queue.sv
module perc_queue
    import perc_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DOT_W  = 12,
    parameter int HIST_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic signed [DOT_W-1:0]  push_score,
    input  logic [HIST_W-1:0]        push_snap,
    input  logic                     pop_old,
    input  logic                     pop_young,
    output logic signed [DOT_W-1:0]  old_score,
    output logic [HIST_W-1:0]        old_snap,
    output logic [HIST_W-1:0]        young_snap,
    output logic                     full,
    output logic                     empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic signed [DOT_W-1:0] sc_mem [DEPTH];
    logic [HIST_W-1:0]       sn_mem [DEPTH];
    logic [PTR_W-1:0]        head, tail, young;
    logic [CNT_W-1:0]        count;
    q_state_e                state, state_nx;
    logic                    pop_any;

    assign pop_any    = pop_old | pop_young;
    assign young      = (tail == '0) ? LAST : tail - 1'b1;
    assign old_score  = sc_mem[head];
    assign old_snap   = sn_mem[head];
    assign young_snap = sn_mem[young];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            Q_EMPTY: if (push) state_nx = Q_PART;                                   // fill
            Q_PART: begin
                if (push && count == CNT_W'(DEPTH - 1))   state_nx = Q_FULL;        // top
                else if (pop_any && count == CNT_W'(1))  state_nx = Q_EMPTY;       // drain
            end
            Q_FULL:  if (pop_any) state_nx = Q_PART;                                // open
            default: state_nx = Q_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            Q_EMPTY: empty = 1'b1;
            Q_FULL:  full  = 1'b1;
            default: ;
        endcase
    end

    // Storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                sc_mem[i] <= '0;
                sn_mem[i] <= '0;
            end
        end else if (push) begin
            sc_mem[tail] <= push_score;
            sn_mem[tail] <= push_snap;
            tail         <= (tail == LAST) ? '0 : tail + 1'b1;
            count        <= count + 1'b1;
        end else if (pop_old) begin
            head  <= (head == LAST) ? '0 : head + 1'b1;
            count <= count - 1'b1;
        end else if (pop_young) begin
            tail  <= young;
            count <= count - 1'b1;
        end
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (state != Q_FULL)); // R10
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_any |-> (state != Q_EMPTY)); // R12
    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) == (count == CNT_W'(DEPTH))); // R10
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop_old, pop_young})); // R11
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (count == $past(count) + 1'b1)); // R5

endmodule

// File: rtl/perc_predictor.sv
module perc_predictor
    import perc_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int HIST_W  = 4,
    parameter int ADDR_W  = 16,
    parameter int Q_DEPTH = 4,
    parameter int THRESH  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic              stall,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              flush_valid
);

    localparam int DOT_W = 9 + $clog2(HIST_W + 1);
    localparam int ALIGN = 2;
    localparam logic [DOT_W:0] THR = (DOT_W + 1)'(THRESH);

    function automatic logic [IDX_W-1:0] tbl_index(input logic [ADDR_W-1:0] a,
                                                   input logic [HIST_W-1:0] h);
        logic [ADDR_W-1:0] mix;
        mix = (a >> ALIGN) ^ ADDR_W'(h);
        return mix[IDX_W-1:0];
    endfunction

    logic [HIST_W-1:0]       ghist;
    op_e                     op;
    logic                    q_full, q_empty;
    logic signed [DOT_W-1:0] p_score, old_score;
    logic [HIST_W-1:0]       old_snap, young_snap;
    logic [HIST_W:0][7:0]    p_w, u_w, u_w_new;
    logic [ADDR_W-1:0]       p_tgt;
    logic [IDX_W-1:0]        p_idx, u_idx;
    logic                    old_dir, mispred, low_conf, train_en;
    logic [DOT_W-1:0]        old_mag;

    // Operation select: update, then flush, then predict.
    always_comb begin
        op = OP_IDLE;
        if (upd_valid) begin
            if (!q_empty) op = OP_UPDATE;
        end else if (flush_valid) begin
            if (!q_empty) op = OP_FLUSH;
        end else if (pred_valid && !q_full) begin
            op = OP_PREDICT;
        end
    end

    // Prediction path
    assign p_idx = tbl_index(pred_addr, ghist);

    perc_dot #(.HIST_W(HIST_W), .DOT_W(DOT_W)) u_dot (
        .weights (p_w),
        .hist    (ghist),
        .score   (p_score)
    );

    // Resolution path
    assign u_idx    = tbl_index(upd_addr, old_snap);
    assign old_dir  = ~old_score[DOT_W-1];
    assign mispred  = (upd_taken != old_dir);
    assign old_mag  = old_score[DOT_W-1] ? DOT_W'(-old_score) : DOT_W'(old_score);
    assign low_conf = ({1'b0, old_mag} <= THR);
    assign train_en = (op == OP_UPDATE) && (mispred || low_conf);

    perc_train #(.HIST_W(HIST_W)) u_train (
        .w_in  (u_w),
        .snap  (old_snap),
        .taken (upd_taken),
        .w_out (u_w_new)
    );

    perc_table #(.IDX_W(IDX_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (p_idx),
        .rd_a_w   (p_w),
        .rd_a_tgt (p_tgt),
        .rd_b_idx (u_idx),
        .rd_b_w   (u_w),
        .wr_w_en  (train_en),
        .wr_t_en  ((op == OP_UPDATE) && upd_taken),
        .wr_idx   (u_idx),
        .wr_w     (u_w_new),
        .wr_tgt   (upd_target)
    );

    perc_queue #(.DEPTH(Q_DEPTH), .DOT_W(DOT_W), .HIST_W(HIST_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (op == OP_PREDICT),
        .push_score (p_score),
        .push_snap  (ghist),
        .pop_old    (op == OP_UPDATE),
        .pop_young  (op == OP_FLUSH),
        .old_score  (old_score),
        .old_snap   (old_snap),
        .young_snap (young_snap),
        .full       (q_full),
        .empty      (q_empty)
    );

    // History register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist <= '0;
        end else begin
            unique case (op)
                OP_PREDICT: ghist <= {ghist[HIST_W-2:0], ~p_score[DOT_W-1]};
                OP_FLUSH:   ghist <= young_snap;
                OP_UPDATE:  if (mispred) ghist <= {old_snap[HIST_W-2:0], upd_taken};
                default:    ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pred_taken  = ~p_score[DOT_W-1];
        pred_target = p_tgt;
        stall       = q_full;
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PREDICT) |=> (ghist[0] == $past(pred_taken))); // R4
    AST_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UPDATE && mispred) |=> (ghist[0] == $past(upd_taken))); // R8
    AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH) |=> (ghist == $past(young_snap))); // R9
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && pred_valid && !upd_valid && !flush_valid) |=> $stable(ghist)); // R10

endmodule

// File: tb/test_perc_predictor.sv
module test_perc_predictor;

    localparam int AW = 16;
    localparam int TH_A = 6;
    localparam int TH_B = 700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pv = 1'b0, uv = 1'b0, ut = 1'b0, fv = 1'b0;
    logic [AW-1:0] pa = '0, ua = '0, utg = '0;
    logic pt_a, pt_b, st_a, st_b;
    logic [AW-1:0] tg_a, tg_b;

    always #5 clk = ~clk;

    perc_predictor #(.THRESH(TH_A)) i_perc_predictor (
        .clk(clk), .rst_n(rst_n), .pred_valid(pv), .pred_addr(pa),
        .pred_taken(pt_a), .pred_target(tg_a), .stall(st_a),
        .upd_valid(uv), .upd_addr(ua), .upd_taken(ut), .upd_target(utg),
        .flush_valid(fv));

    perc_predictor #(.THRESH(TH_B)) i_perc_predictor_sat (
        .clk(clk), .rst_n(rst_n), .pred_valid(pv), .pred_addr(pa),
        .pred_taken(pt_b), .pred_target(tg_b), .stall(st_b),
        .upd_valid(uv), .upd_addr(ua), .upd_taken(ut), .upd_target(utg),
        .flush_valid(fv));

    // Reference model state
    int w_m  [2][8][5];
    int tg_m [2][8];
    int gh_m [2];
    int qs_m [2][4];
    int qh_m [2][4];
    int qa_m [4];
    int q_head = 0, q_cnt = 0;
    int th_m [2] = '{TH_A, TH_B};

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    string tag = "R1 reset";
    int rng = 32'h1234_5678;

    function automatic int idx_of(input int a, input int h);
        return ((a >> 2) ^ h) & 7;
    endfunction

    function automatic int score_of(input int k, input int i, input int h);
        int s = w_m[k][i][0];
        for (int j = 0; j < 4; j++) s += (((h >> j) & 1) != 0) ? w_m[k][i][j+1] : -w_m[k][i][j+1];
        return s;
    endfunction

    function automatic int clampw(input int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    function automatic int next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >>> 17);
        rng = rng ^ (rng << 5);
        return rng & 32'h7fff_ffff;
    endfunction

    task automatic check(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_outputs();
        for (int k = 0; k < 2; k++) begin
            int i = idx_of(int'(pa), gh_m[k]);
            int s = score_of(k, i, gh_m[k]);
            check(k == 0 ? "R2 R3 direction A" : "R2 R3 direction B",
                  k == 0 ? int'(pt_a) : int'(pt_b), (s >= 0) ? 1 : 0);
            check(k == 0 ? "R7 target A" : "R7 target B",
                  k == 0 ? int'(tg_a) : int'(tg_b), tg_m[k][i]);
            check(k == 0 ? "R10 stall A" : "R10 stall B",
                  k == 0 ? int'(st_a) : int'(st_b), (q_cnt == 4) ? 1 : 0);
        end
    endtask

    task automatic model_step();
        int young = (q_head + q_cnt + 3) % 4;
        int tail  = (q_head + q_cnt) % 4;
        int bt = ut ? 1 : 0;
        if (uv) begin
            if (q_cnt > 0) begin
                for (int k = 0; k < 2; k++) begin
                    int sc = qs_m[k][q_head];
                    int sn = qh_m[k][q_head];
                    int i  = idx_of(int'(ua), sn);
                    bit mis = (bt == 1) != (sc >= 0);
                    int mag = (sc < 0) ? -sc : sc;
                    if (mis || mag <= th_m[k]) begin
                        w_m[k][i][0] = clampw(w_m[k][i][0] + (bt == 1 ? 1 : -1));
                        for (int j = 0; j < 4; j++)
                            w_m[k][i][j+1] = clampw(w_m[k][i][j+1] + ((((sn >> j) & 1) == bt) ? 1 : -1));
                    end
                    if (bt == 1) tg_m[k][i] = int'(utg);
                    if (mis) gh_m[k] = ((sn << 1) | bt) & 15;
                end
                q_head = (q_head + 1) % 4;
                q_cnt--;
            end
        end else if (fv) begin
            if (q_cnt > 0) begin
                for (int k = 0; k < 2; k++) gh_m[k] = qh_m[k][young];
                q_cnt--;
            end
        end else if (pv && q_cnt < 4) begin
            for (int k = 0; k < 2; k++) begin
                int h = gh_m[k];
                int s = score_of(k, idx_of(int'(pa), h), h);
                qs_m[k][tail] = s;
                qh_m[k][tail] = h;
                gh_m[k] = ((h << 1) | ((s >= 0) ? 1 : 0)) & 15;
            end
            qa_m[tail] = int'(pa);
            q_cnt++;
        end
    endtask

    task automatic cycle(input bit p, input int paddr, input bit u, input int uaddr,
                         input bit utk, input int utgt, input bit f);
        @(negedge clk);
        pv = p; pa = AW'(paddr); uv = u; ua = AW'(uaddr); ut = utk; utg = AW'(utgt); fv = f;
        #2;
        compare_outputs();
        @(posedge clk);
        model_step();
    endtask

    task automatic predict(input int a);
        cycle(1'b1, a, 1'b0, 0, 1'b0, 0, 1'b0);
    endtask

    task automatic resolve(input bit t, input int tgt);
        cycle(1'b0, 0, 1'b1, qa_m[q_head], t, tgt, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            gh_m[k] = 0;
            for (int i = 0; i < 8; i++) begin
                tg_m[k][i] = 0;
                for (int j = 0; j < 5; j++) w_m[k][i][j] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tag = "R1 reset";
        cycle(1'b0, 8'h40, 1'b0, 0, 1'b0, 0, 1'b0);

        tag = "R12 empty update/flush";
        cycle(1'b0, 0, 1'b1, 8'h40, 1'b1, 16'h1234, 1'b0);
        cycle(1'b0, 8'h44, 1'b0, 0, 1'b0, 0, 1'b1);
        cycle(1'b0, 8'h40, 1'b0, 0, 1'b0, 0, 1'b0);

        tag = "R4 R5 R10 fill";
        for (int n = 0; n < 6; n++) predict(8'h40 + 4 * n);
        cycle(1'b0, 8'h48, 1'b0, 0, 1'b0, 0, 1'b0);

        tag = "R5 R6 R8 resolve";
        resolve(1'b0, 16'h0100);
        resolve(1'b1, 16'h0204);
        resolve(1'b0, 16'h0300);
        resolve(1'b1, 16'h0408);
        cycle(1'b0, 8'h44, 1'b0, 0, 1'b0, 0, 1'b0);

        tag = "R9 flush";
        predict(8'h50); predict(8'h54); predict(8'h58);
        cycle(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b1);
        cycle(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b1);
        predict(8'h5c);

        tag = "R11 priority";
        cycle(1'b1, 8'h60, 1'b1, qa_m[q_head], 1'b1, 16'h0777, 1'b1);
        cycle(1'b1, 8'h64, 1'b0, 0, 1'b0, 0, 1'b1);
        cycle(1'b1, 8'h68, 1'b1, 0, 1'b0, 0, 1'b0);
        cycle(1'b1, 8'h6c, 1'b0, 0, 1'b0, 0, 1'b0);

        tag = "R2 R3 R8 R9 random";
        for (int n = 0; n < 3000; n++) begin
            int r = next_rand();
            int br = (r >> 4) & 3;
            int a = 8'h40 + 4 * br + 16 * ((r >> 8) & 1);
            int op = r & 7;
            if (op <= 3) predict(a);
            else if (op <= 5) begin
                int ob = (qa_m[q_head] >> 2) & 3;
                bit t = (ob == 0) ? 1'b1 : (ob == 1) ? 1'b0 : (ob == 2) ? bit'(n & 1) : bit'((r >> 12) & 1);
                resolve(t, 16'h2000 + qa_m[q_head] + n);
            end else if (op == 6) cycle(1'b0, a, 1'b0, 0, 1'b0, 0, 1'b1);
            else cycle(1'b1, a, (r >> 13) & 1, qa_m[q_head], (r >> 14) & 1, 16'h3000 + n, 1'b1);
        end

        tag = "R6 saturation";
        while (q_cnt > 0) resolve(1'b1, 16'h0abc);
        for (int n = 0; n < 320; n++) begin
            predict(8'h80);
            resolve(1'b1, 16'h0c00 + n);
        end
        for (int n = 0; n < 320; n++) begin
            predict(8'h80);
            resolve(1'b0, 16'h0d00);
        end
        cycle(1'b0, 8'h80, 1'b0, 0, 1'b0, 0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule